// File: doc/BRIEF.md
# Timed Priority Resource Arbiter

This block shares one resource between two users. A low-priority user holds the resource by default. A high-priority user can take it over through a request, grant and in-use handshake with fixed cycle timing.

The design has two cooperating state machines:

- **Front end.** It turns a rising edge on the high-priority user's call line into a held request. Once the grant has settled, it raises an in-use flag.
- **Arbiter core.** It withdraws the default grant and gives the low-priority side a fixed drain window if that side reports it is still busy. It then grants the high-priority side and holds that grant for an exact tenure, counted from the rise of the in-use flag. After the tenure the grant returns to the low-priority user.

All delays are counted in clock cycles by down-counters, all outputs are registered, and reset is synchronous and active high.

Top module: `prio_tenure_arbiter`

## Requirements
- R1: While and directly after reset, lp_grant is 1 and hp_grant, hp_req and hp_use are 0.
- R2: In the idle state, a rising edge of hp_call, seen at a clock edge, sets hp_req at that same edge. hp_req stays high until hp_use rises.
- R3: lp_grant falls one clock after hp_req rises.
- R4: The lp_busy value sampled one clock after hp_req rises sets when hp_grant rises:
  - if that value is 0, hp_grant rises at that same edge (one clock after hp_req);
  - if that value is 1, hp_grant rises HANDOFF_WAIT clocks after hp_req rose.
- R5: hp_use rises USE_DELAY clocks after hp_grant rises, at the same edge at which hp_req falls. hp_req and hp_use are never high together.
- R6: hp_grant falls exactly TENURE clocks after hp_use rises, and lp_grant rises at that same edge.
- R7: hp_use falls one clock after hp_grant falls.
- R8: hp_grant and lp_grant are never high in the same cycle.
- R9: A rising edge of hp_call is ignored while a takeover is in progress, up to and including the edge at which hp_use falls. A call line that is held high starts no further takeover.
- R10: hp_grant rises no more than HANDOFF_WAIT clocks after hp_req rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hp_call | input | 1 | Request line of the high-priority user; its rising edge starts a takeover |
| lp_busy | input | 1 | Low-priority user still using the resource |
| hp_req | output | 1 | Held high-priority request |
| hp_use | output | 1 | High-priority side is using the resource |
| hp_grant | output | 1 | Grant to the high-priority side |
| lp_grant | output | 1 | Grant to the low-priority side (default owner) |

## Verification
The bench builds the block with its default values: a drain window of 4 cycles, a settle delay of 2 and a tenure of 64. With these values a full takeover lasts about 70 cycles, so many takeovers fit in a short run. Both the busy-drain path and the immediate-grant path are reached, as are calls landing on the last cycle of a tenure. The reference model works only from event timestamps. On its own counters the bench also measures the grant latency and the tenure length, and checks mutual exclusion on every cycle.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
   typedef enum logic [1:0] {FE_IDLE, FE_ASK, FE_SETTLE, FE_OWN} fe_state_t;
   typedef enum logic [1:0] {AR_LOW, AR_DRAIN, AR_ARMED, AR_HOLD} ar_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction
endpackage

// File: rtl/tpa_rise.sv
module tpa_rise (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b0;
      else     prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/tpa_hp_front.sv
module tpa_hp_front
   import tpa_pkg::*;
#(
   parameter int unsigned USE_DELAY = 2,
   parameter int unsigned CW        = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic call_rise,
   input  logic hp_grant,
   output logic hp_req,
   output logic hp_use
);
   fe_state_t       st;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= FE_IDLE;
         hp_req <= 1'b0;
         hp_use <= 1'b0;
         cnt    <= '0;
      end else begin
         case (st)
            FE_IDLE: if (call_rise) begin
               hp_req <= 1'b1;
               st     <= FE_ASK;
            end
            FE_ASK: if (hp_grant) begin
               cnt <= CW'(USE_DELAY - 2);
               st  <= FE_SETTLE;
            end
            FE_SETTLE: begin
               if (cnt == '0) begin
                  hp_use <= 1'b1;
                  hp_req <= 1'b0;
                  st     <= FE_OWN;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FE_OWN: if (!hp_grant) begin
               hp_use <= 1'b0;
               st     <= FE_IDLE;
            end
            default: st <= FE_IDLE;
         endcase
      end
   end

   // R5
   req_use_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(hp_req && hp_use));

   // R7
   use_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(hp_grant) |=> !hp_use);

   // R5
   use_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hp_use) |-> hp_grant);
endmodule

// File: rtl/tpa_arb_core.sv
module tpa_arb_core
   import tpa_pkg::*;
#(
   parameter int unsigned HANDOFF_WAIT = 4,
   parameter int unsigned TENURE       = 64,
   parameter int unsigned CW           = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic hp_req,
   input  logic lp_busy,
   input  logic hp_use,
   output logic hp_grant,
   output logic lp_grant
);
   ar_state_t       st;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= AR_LOW;
         hp_grant <= 1'b0;
         lp_grant <= 1'b1;
         cnt      <= '0;
      end else begin
         case (st)
            AR_LOW: if (hp_req) begin
               lp_grant <= 1'b0;
               if (lp_busy) begin
                  cnt <= CW'(HANDOFF_WAIT - 2);
                  st  <= AR_DRAIN;
               end else begin
                  hp_grant <= 1'b1;
                  st       <= AR_ARMED;
               end
            end
            AR_DRAIN: begin
               if (cnt == '0) begin
                  hp_grant <= 1'b1;
                  st       <= AR_ARMED;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            AR_ARMED: if (hp_use) begin
               cnt <= CW'(TENURE - 2);
               st  <= AR_HOLD;
            end
            AR_HOLD: begin
               if (cnt == '0) begin
                  hp_grant <= 1'b0;
                  lp_grant <= 1'b1;
                  st       <= AR_LOW;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= AR_LOW;
         endcase
      end
   end

   // Observation counters for the timing checks below
   logic [CW:0] lat_cnt;
   logic [CW:0] ten_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_cnt <= '0;
         ten_cnt <= '0;
      end else begin
         lat_cnt <= (hp_req && !hp_grant) ? lat_cnt + 1'b1 : '0;
         ten_cnt <= (hp_use && hp_grant)  ? ten_cnt + 1'b1 : '0;
      end
   end

   // R8
   grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(hp_grant && lp_grant));

   // R10
   grant_latency_chk: assert property (@(posedge clk) disable iff (rst)
      lat_cnt <= (CW+1)'(HANDOFF_WAIT));

   // R6
   tenure_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(hp_grant) |-> (ten_cnt == (CW+1)'(TENURE)));

   // R3
   lp_drop_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hp_req) |=> !lp_grant);

   // R6
   lp_return_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(hp_grant) |-> lp_grant);
endmodule

// File: rtl/prio_tenure_arbiter.sv
module prio_tenure_arbiter
   import tpa_pkg::*;
#(
   parameter int unsigned HANDOFF_WAIT = 4,
   parameter int unsigned USE_DELAY    = 2,
   parameter int unsigned TENURE       = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic hp_call,
   input  logic lp_busy,
   output logic hp_req,
   output logic hp_use,
   output logic hp_grant,
   output logic lp_grant
);
   localparam int unsigned CW = cnt_bits(max3(HANDOFF_WAIT, USE_DELAY, TENURE));

   if (HANDOFF_WAIT < 2) begin : g_bad_wait
      $error("HANDOFF_WAIT must be at least 2");
   end
   if (USE_DELAY < 2) begin : g_bad_use
      $error("USE_DELAY must be at least 2");
   end
   if (TENURE < 2) begin : g_bad_tenure
      $error("TENURE must be at least 2");
   end

   logic call_rise;

   tpa_rise u_rise (
      .clk  (clk),
      .rst  (rst),
      .lvl  (hp_call),
      .rise (call_rise)
   );

   tpa_hp_front #(.USE_DELAY(USE_DELAY), .CW(CW)) u_front (
      .clk       (clk),
      .rst       (rst),
      .call_rise (call_rise),
      .hp_grant  (hp_grant),
      .hp_req    (hp_req),
      .hp_use    (hp_use)
   );

   tpa_arb_core #(.HANDOFF_WAIT(HANDOFF_WAIT), .TENURE(TENURE), .CW(CW)) u_core (
      .clk      (clk),
      .rst      (rst),
      .hp_req   (hp_req),
      .lp_busy  (lp_busy),
      .hp_use   (hp_use),
      .hp_grant (hp_grant),
      .lp_grant (lp_grant)
   );
endmodule

// File: tb/prio_tenure_arbiter_bench.sv
`timescale 1ns/1ps
module prio_tenure_arbiter_bench;
   localparam int HW  = 4;
   localparam int UD  = 2;
   localparam int TEN = 64;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hp_call = 1'b0;
   logic lp_busy = 1'b0;
   logic hp_req, hp_use, hp_grant, lp_grant;

   always #4 clk = ~clk;

   prio_tenure_arbiter #(.HANDOFF_WAIT(HW), .USE_DELAY(UD), .TENURE(TEN)) u_prio_tenure_arbiter (
      .clk(clk), .rst(rst), .hp_call(hp_call), .lp_busy(lp_busy),
      .hp_req(hp_req), .hp_use(hp_use), .hp_grant(hp_grant), .lp_grant(lp_grant)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
      end
   endtask

   // Reference model: timestamps of takeover events
   bit e_req, e_use, e_hg, e_lp;
   bit act_m, rq_prev;
   int cyc, t0, tg, tu, tf;

   always @(posedge clk) begin
      if (rst) begin
         e_req = 0; e_use = 0; e_hg = 0; e_lp = 1;
         act_m = 0; rq_prev = 0; cyc = 0;
         t0 = -100; tg = -100; tu = -100; tf = -100;
      end else begin
         cyc++;
         if (!act_m && hp_call && !rq_prev) begin
            act_m = 1; t0 = cyc; e_req = 1;
            tg = -100; tu = -100; tf = -100;
         end else if (act_m) begin
            if (cyc == t0 + 1) begin
               e_lp = 0;
               tg = lp_busy ? t0 + HW : t0 + 1;
            end
            if (cyc == tg) begin e_hg = 1; tu = tg + UD; end
            if (cyc == tu) begin e_use = 1; e_req = 0; tf = tu + TEN; end
            if (cyc == tf) begin e_hg = 0; e_lp = 1; end
            if (cyc == tf + 1) begin e_use = 0; act_m = 0; end
         end
         rq_prev = hp_call;
      end
   end

   // Per-cycle comparison and measured timing
   bit p_req, p_use, p_hg;
   int lat, ten;

   always @(negedge clk) begin
      if (!rst) begin
         check("R2", "hp_req", hp_req, e_req);
         check("R3", "lp_grant", lp_grant, e_lp);
         check("R4", "hp_grant", hp_grant, e_hg);
         check("R5", "hp_use", hp_use, e_use);
         check("R8", "grant overlap", hp_grant & lp_grant, 0);

         if (hp_req && !p_req) lat = 1;
         else if (hp_grant && !p_hg) check("R10", "grant latency ok", int'(lat <= HW), 1);
         else if (hp_req && !hp_grant) lat++;

         if (hp_use && !p_use) ten = 1;
         else if (!hp_grant && p_hg) check("R6", "tenure cycles", ten, TEN);
         else if (hp_grant && hp_use) ten++;
      end
      p_req = hp_req; p_use = hp_use; p_hg = hp_grant;
   end

   task automatic wait_neg(input int k);
      for (int i = 0; i < k; i++) @(negedge clk);
   endtask

   task automatic pulse;
      @(negedge clk) hp_call = 1'b1;
      @(negedge clk) hp_call = 1'b0;
   endtask

   bit done = 0;

   initial begin
      wait_neg(3);
      // R1: reset state
      check("R1", "lp_grant in reset", lp_grant, 1);
      check("R1", "hp_grant in reset", hp_grant, 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "hp_req after reset", hp_req, 0);
      check("R1", "hp_use after reset", hp_use, 0);

      // R4: low side idle, immediate grant
      pulse();
      wait_neg(80);

      // R4: low side busy, drain window
      lp_busy = 1'b1;
      pulse();
      wait_neg(3);
      lp_busy = 1'b0;
      wait_neg(80);

      // R9: call held high through the takeover, extra edges ignored
      lp_busy = 1'b1;
      @(negedge clk) hp_call = 1'b1;
      wait_neg(20);
      hp_call = 1'b0;
      pulse();
      pulse();
      lp_busy = 1'b0;
      wait_neg(30);
      @(negedge clk) hp_call = 1'b1;
      wait_neg(60);
      check("R9", "hp_req after held call", hp_req, 0);
      check("R9", "lp_grant after held call", lp_grant, 1);
      hp_call = 1'b0;
      wait_neg(5);

      // R9: edge landing on the final cycles of a tenure
      pulse();
      wait_neg(TEN + UD - 2);
      for (int k = 0; k < 6; k++) pulse();
      wait_neg(90);

      // R2: back-to-back calls as soon as idle
      for (int k = 0; k < 3; k++) begin
         lp_busy = k[0];
         pulse();
         wait_neg(TEN + HW + UD + 1);
      end
      wait_neg(10);

      // R1: mid-run reset
      pulse();
      wait_neg(10);
      rst = 1'b1;
      wait_neg(2);
      check("R1", "hp_grant after mid reset", hp_grant, 0);
      check("R1", "lp_grant after mid reset", lp_grant, 1);
      rst = 1'b0;
      pulse();
      wait_neg(80);
      done = 1;
   end

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule